// File: doc/BRIEF.md
# Nonvolatile SRAM recall controller

This block pairs a small working SRAM with a shadow nonvolatile array held in registers, and it decides when the two exchange contents. A recall fills the SRAM from the shadow array in two passes: first it zeroes every SRAM word, then it copies every shadow word into the SRAM word with the same address. A store runs the other way and copies every SRAM word into the shadow array. While neither runs, the SRAM serves a plain single-port read/write interface.

Two clean digital supply flags drive the automatic behaviour. While the "above reset level" flag is low, a power-up recall request is latched and kept. That recall starts only once the "above switch level" flag is high. The same switch flag protects the shadow array: no store begins, and no shadow word is written, while it is low. A recall can also be requested by a pulse. If one arrives while the block is busy, it waits and runs next. A store pulse that arrives while the block is busy is discarded. If a write is being driven to the SRAM at the moment a power-up recall finishes, the addressed word is damaged and a sticky flag reports it.

Top module: `nvs_recall_top`

## Requirements
- R1: After `rst`, `busy`, `rdata` and `corrupt_err` are all 0.
- R2: While `busy` is low, `ce`=1 with `we`=1 writes `wdata` to `addr`. `ce`=1 with `we`=0 puts the word at `addr` on `rdata` one clock later. In every other cycle `rdata` is 0.
- R3: A recall leaves every SRAM word equal to the shadow word at the same address. The SRAM is zeroed first and filled afterwards.
- R4: A recall never writes the shadow array, and repeated or back-to-back recalls yield the same SRAM contents.
- R5: While `sup_rst_ok` is low, a power-up recall is latched. It does not start while `sup_sw_ok` is low. It starts (`busy` high) on the clock after `sup_sw_ok` is seen high.
- R6: `busy` stays high for exactly `RECALL_CYC` clocks during a recall and for exactly `STORE_CYC` clocks during a store.
- R7: While `busy` is high, external writes are ignored and `rdata` is 0.
- R8: A store (a `store_req` pulse while idle with `sup_sw_ok` high) copies every SRAM word into the shadow array.
- R9: While `sup_sw_ok` is low, a `store_req` starts nothing (`busy` stays low) and the shadow array is not written.
- R10: A `store_req` during `busy` is dropped. A `recall_req` during `busy` is held, and its recall starts within two clocks after `busy` falls.
- R11: If `ce` and `we` are both 1 in the last cycle of a power-up recall, the word at `addr` becomes the bitwise inverse of `wdata` and `corrupt_err` is set. `corrupt_err` stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_rst_ok | input | 1 | Supply is above the reset level |
| sup_sw_ok | input | 1 | Supply is above the switch level |
| recall_req | input | 1 | Recall request pulse |
| store_req | input | 1 | Store request pulse |
| ce | input | 1 | SRAM chip enable |
| we | input | 1 | SRAM write enable (1 = write) |
| addr | input | ADDR_W | SRAM word address |
| wdata | input | DATA_W | SRAM write data |
| busy | output | 1 | Recall or store in progress |
| rdata | output | DATA_W | Read data, 0 unless a read was accepted |
| corrupt_err | output | 1 | Sticky power-up recall write collision flag |

## Verification
Suppose the sequencer counter or state is wrong. Then `busy` ends on the wrong clock, and a width measured against `RECALL_CYC` or `STORE_CYC` shows the error as soon as the operation ends. A bad address or data select in the copy phase leaves wrong words behind. This shows up on the first read after the recall. A shadow write that escapes its gate stays hidden until a later recall, so every store-related check ends with a recall and a full read-back. A pending flag that was lost or cleared too early shows up as `busy` staying low at a point where a recall must start.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECALL = 2'd1,
    ST_STORE  = 2'd2
  } nvs_state_e;

  // Source of the data word written into the working SRAM
  typedef enum logic [1:0] {
    SRC_EXT     = 2'd0,
    SRC_ZERO    = 2'd1,
    SRC_NV      = 2'd2,
    SRC_EXT_INV = 2'd3
  } nvs_src_e;

endpackage

// File: rtl/nvs_ram.sv
// Single-port working SRAM, read-first, synchronous read (block RAM friendly)
module nvs_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/nvs_shadow.sv
// Shadow nonvolatile array: register file, combinational read, reset to blank
module nvs_shadow #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) cells[g] <= '0;
      else if (we && (waddr == AW'(g))) cells[g] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_req.sv
// Pending recall latches: power-up (supply) and requested (pulse)
module nvs_req (
  input  logic clk,
  input  logic rst,
  input  logic sup_rst_ok,
  input  logic recall_req,
  input  logic clr_pu,
  input  logic clr_sw,
  output logic pu_pend,
  output logic sw_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_pend <= 1'b0;
      sw_pend <= 1'b0;
    end else begin
      // a low supply always wins over a clear
      pu_pend <= !sup_rst_ok || (pu_pend && !clr_pu);
      sw_pend <= recall_req || (sw_pend && !clr_sw);
    end
  end
endmodule

// File: rtl/nvs_seq.sv
// Recall / store sequencer and SRAM port arbitration
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int AW         = 4,
  parameter int RECALL_CYC = 40,
  parameter int STORE_CYC  = 20,
  parameter int CNT_W      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup_sw_ok,
  input  logic          pu_pend,
  input  logic          sw_pend,
  input  logic          store_req,
  input  logic          ext_ce,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  output logic          busy,
  output logic          in_recall,
  output logic          ext_ok,
  output logic          clr_pu,
  output logic          clr_sw,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  nvs_src_e             ram_src,
  output logic [AW-1:0] nv_raddr,
  output logic          sh_we,
  output logic [AW-1:0] sh_waddr,
  output logic          corrupt_set,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [CNT_W-1:0] RC_LAST = CNT_W'(RECALL_CYC - 1);
  localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] N_WORDS = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] N_TWICE = CNT_W'(2 * DEPTH);

  nvs_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             is_pu;
  logic             go_rc, go_st, last_rc, last_st;
  logic             idle;

  assign idle    = (state == ST_IDLE);
  assign go_rc   = idle && ((pu_pend && sup_sw_ok) || sw_pend);
  assign go_st   = idle && !go_rc && store_req && sup_sw_ok;
  assign ext_ok  = idle && !go_rc && !go_st;
  assign clr_sw  = go_rc;
  assign clr_pu  = go_rc && pu_pend && sup_sw_ok;
  assign last_rc = (state == ST_RECALL) && (cnt == RC_LAST);
  assign last_st = (state == ST_STORE) && (cnt == ST_LAST);
  assign in_recall = (state == ST_RECALL);
  assign cnt_o   = cnt;

  assign nv_raddr = AW'(cnt - N_WORDS);
  assign sh_waddr = AW'(cnt - CNT_W'(1));
  assign sh_we    = (state == ST_STORE) && (cnt != '0) && (cnt <= N_WORDS)
                    && sup_sw_ok;

  // SRAM port owner
  always_comb begin
    ram_we      = 1'b0;
    ram_addr    = ext_addr;
    ram_src     = SRC_EXT;
    corrupt_set = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ram_we = ext_ok && ext_ce && ext_we;
      end
      ST_RECALL: begin
        if (cnt < N_WORDS) begin
          ram_we   = 1'b1;
          ram_addr = AW'(cnt);
          ram_src  = SRC_ZERO;
        end else if (cnt < N_TWICE) begin
          ram_we   = 1'b1;
          ram_addr = nv_raddr;
          ram_src  = SRC_NV;
        end else if (last_rc && is_pu && ext_ce && ext_we) begin
          ram_we      = 1'b1;
          ram_addr    = ext_addr;
          ram_src     = SRC_EXT_INV;
          corrupt_set = 1'b1;
        end
      end
      ST_STORE: begin
        ram_addr = AW'(cnt);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      is_pu <= 1'b0;
      busy  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (go_rc) begin
            state <= ST_RECALL;
            is_pu <= clr_pu;
            busy  <= 1'b1;
          end else if (go_st) begin
            state <= ST_STORE;
            busy  <= 1'b1;
          end
        end
        ST_RECALL: begin
          if (last_rc) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STORE: begin
          if (last_st) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/nvs_recall_top.sv
module nvs_recall_top
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int RECALL_CYC = 40,   // must exceed 2 * 2**ADDR_W
  parameter int STORE_CYC  = 20    // must exceed 2**ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sup_rst_ok,
  input  logic              sup_sw_ok,
  input  logic              recall_req,
  input  logic              store_req,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic              corrupt_err
);
  localparam int MAX_CYC = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              pu_pend, sw_pend, clr_pu, clr_sw;
  logic              in_recall, ext_ok, ram_we, sh_we, corrupt_set;
  logic [ADDR_W-1:0] ram_addr, nv_raddr, sh_waddr;
  nvs_src_e          ram_src;
  logic [DATA_W-1:0] ram_wdata, ram_q, nv_rdata;
  logic [CNT_W-1:0]  seq_cnt;
  logic              rd_v;

  nvs_req u_req (
    .clk(clk), .rst(rst), .sup_rst_ok(sup_rst_ok), .recall_req(recall_req),
    .clr_pu(clr_pu), .clr_sw(clr_sw), .pu_pend(pu_pend), .sw_pend(sw_pend)
  );

  nvs_seq #(
    .AW(ADDR_W), .RECALL_CYC(RECALL_CYC), .STORE_CYC(STORE_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .sup_sw_ok(sup_sw_ok), .pu_pend(pu_pend),
    .sw_pend(sw_pend), .store_req(store_req), .ext_ce(ce), .ext_we(we),
    .ext_addr(addr), .busy(busy), .in_recall(in_recall), .ext_ok(ext_ok),
    .clr_pu(clr_pu), .clr_sw(clr_sw), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_src(ram_src), .nv_raddr(nv_raddr), .sh_we(sh_we),
    .sh_waddr(sh_waddr), .corrupt_set(corrupt_set), .cnt_o(seq_cnt)
  );

  always_comb begin
    unique case (ram_src)
      SRC_ZERO:    ram_wdata = '0;
      SRC_NV:      ram_wdata = nv_rdata;
      SRC_EXT_INV: ram_wdata = ~wdata;
      default:     ram_wdata = wdata;
    endcase
  end

  nvs_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  nvs_shadow #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
    .clk(clk), .rst(rst), .we(sh_we), .waddr(sh_waddr), .wdata(ram_q),
    .raddr(nv_raddr), .rdata(nv_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v        <= 1'b0;
      corrupt_err <= 1'b0;
    end else begin
      rd_v <= ext_ok && ce && !we;
      if (corrupt_set) corrupt_err <= 1'b1;
    end
  end

  assign rdata = rd_v ? ram_q : '0;
endmodule

// File: rtl/nvs_recall_chk.sv
module nvs_recall_chk #(
  parameter int RECALL_CYC = 40,
  parameter int CNT_W      = 6,
  parameter int DW         = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sup_rst_ok,
  input logic             sup_sw_ok,
  input logic             busy,
  input logic [DW-1:0]    rdata,
  input logic             corrupt_err,
  input logic             in_recall,
  input logic             sh_we,
  input logic             pu_pend,
  input logic             sw_pend,
  input logic [CNT_W-1:0] cnt
);
  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rdata == '0));

  p_recall_keeps_nv_r4: assert property (@(posedge clk) disable iff (rst)
    in_recall |-> !sh_we);

  p_store_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !sup_sw_ok |-> !sh_we);

  p_nv_write_busy_r8: assert property (@(posedge clk) disable iff (rst)
    sh_we |-> busy);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    corrupt_err |=> corrupt_err);

  p_pu_latch_r5: assert property (@(posedge clk) disable iff (rst)
    !sup_rst_ok |=> pu_pend);

  p_no_early_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sup_sw_ok && !sw_pend) |=> !busy);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(RECALL_CYC));
endmodule

bind nvs_recall_top nvs_recall_chk #(
  .RECALL_CYC(RECALL_CYC), .CNT_W(CNT_W), .DW(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .sup_rst_ok(sup_rst_ok), .sup_sw_ok(sup_sw_ok),
  .busy(busy), .rdata(rdata), .corrupt_err(corrupt_err),
  .in_recall(in_recall), .sh_we(sh_we), .pu_pend(pu_pend),
  .sw_pend(sw_pend), .cnt(seq_cnt)
);

// File: tb/nvs_recall_top_bench.sv
module nvs_recall_top_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int RC = 40;
  localparam int SC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sup_rst_ok = 1'b0, sup_sw_ok = 1'b0;
  logic          recall_req = 1'b0, store_req = 1'b0;
  logic          ce = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, corrupt_err;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvs_recall_top #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYC(RC), .STORE_CYC(SC))
  u_nvs_recall_top (
    .clk(clk), .rst(rst), .sup_rst_ok(sup_rst_ok), .sup_sw_ok(sup_sw_ok),
    .recall_req(recall_req), .store_req(store_req), .ce(ce), .we(we),
    .addr(addr), .wdata(wdata), .busy(busy), .rdata(rdata),
    .corrupt_err(corrupt_err)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat1(int i); return DW'(i * 7 + 3); endfunction
  function automatic logic [DW-1:0] pat2(int i); return DW'(8'hF0 ^ i); endfunction
  function automatic logic [DW-1:0] pat3(int i); return DW'(i * 13 + 1); endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    ce = 1; we = 1; addr = AW'(a); wdata = d; tick();
    ce = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    ce = 1; we = 0; addr = AW'(a); tick();
    d = rdata; ce = 0;
  endtask

  // wait for busy to rise (bounded), then count high cycles
  task automatic busy_len(output int n);
    int w = 0;
    n = 0;
    while (!busy && w < 10) begin tick(); w++; end
    while (busy && n < 1000) begin n++; tick(); end
  endtask

  task automatic pulse_recall(); recall_req = 1; tick(); recall_req = 0; endtask
  task automatic pulse_store();  store_req = 1;  tick(); store_req = 0;  endtask

  task automatic check_all(input int which, input string tag);
    logic [DW-1:0] d, e;
    for (int i = 0; i < NW; i++) begin
      rd(i, d);
      e = (which == 1) ? pat1(i) : (which == 0 ? '0 : pat3(i));
      chk(d == e, tag, d, e);
    end
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) tick();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rdata == 0, "R1 rdata", rdata, 0);
    chk(corrupt_err == 0, "R1 err", corrupt_err, 0);
    rst = 0;
  endtask

  task automatic t_powerup();
    int n;
    repeat (10) tick();
    chk(busy == 0, "R5 no start below reset", busy, 0);
    sup_rst_ok = 1; repeat (5) tick();
    chk(busy == 0, "R5 no start below switch", busy, 0);
    sup_sw_ok = 1; tick();
    chk(busy == 1, "R5 start after switch", busy, 1);
    busy_len(n);
    chk(n == RC, "R6 recall length", n, RC);
    check_all(0, "R3 blank recall");
  endtask

  task automatic t_rw();
    logic [DW-1:0] d;
    for (int i = 0; i < NW; i++) wr(i, pat1(i));
    check_all(1, "R2 readback");
    tick();
    chk(rdata == 0, "R2 idle rdata", rdata, 0);
    rd(9, d);
    chk(d == pat1(9), "R2 single read", d, pat1(9));
  endtask

  task automatic t_store();
    int n;
    pulse_store();
    busy_len(n);
    chk(n == SC, "R6 store length", n, SC);
    for (int i = 0; i < NW; i++) wr(i, pat2(i));
    pulse_recall();
    busy_len(n);
    check_all(1, "R8 store then recall");
  endtask

  task automatic t_back_to_back();
    int n;
    for (int i = 0; i < NW; i++) wr(i, pat3(i));
    pulse_recall();
    while (!busy) tick();
    repeat (5) tick();
    pulse_recall();
    while (busy) tick();
    tick(); tick();
    chk(busy == 1, "R10 queued recall runs", busy, 1);
    busy_len(n);
    chk(n == RC - 2 || n == RC - 1 || n == RC, "R6 queued length", n, RC);
    check_all(1, "R4 repeated recall");
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] d;
    pulse_recall();
    while (!busy) tick();
    repeat (3) tick();
    wr(5, 8'hAA);
    rd(5, d);
    chk(d == 0, "R7 read while busy", d, 0);
    pulse_store();
    while (busy) tick();
    repeat (10) begin
      tick();
      chk(busy == 0, "R10 store dropped", busy, 0);
    end
    rd(5, d);
    chk(d == pat1(5), "R7 write ignored", d, pat1(5));
  endtask

  task automatic t_store_gate();
    int n;
    sup_sw_ok = 0;
    for (int i = 0; i < NW; i++) wr(i, pat2(i));
    pulse_store();
    repeat (5) begin
      tick();
      chk(busy == 0, "R9 store blocked", busy, 0);
    end
    sup_sw_ok = 1; tick();
    pulse_recall();
    busy_len(n);
    check_all(1, "R9 shadow unchanged");
  endtask

  task automatic t_corrupt();
    logic [DW-1:0] d;
    int w = 0;
    chk(corrupt_err == 0, "R11 err clear before", corrupt_err, 0);
    sup_rst_ok = 0; sup_sw_ok = 0; repeat (3) tick();
    sup_rst_ok = 1; sup_sw_ok = 1;
    ce = 1; we = 1; addr = 4'd3; wdata = 8'h5A;
    tick();
    while (busy && w < 1000) begin tick(); w++; end
    ce = 0; we = 0;
    chk(corrupt_err == 1, "R11 err set", corrupt_err, 1);
    rd(3, d);
    chk(d == 8'hA5, "R11 word corrupted", d, 8'hA5);
    rd(2, d);
    chk(d == pat1(2), "R3 neighbour intact", d, pat1(2));
    repeat (5) tick();
    chk(corrupt_err == 1, "R11 err sticky", corrupt_err, 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_rw();
    t_store();
    t_back_to_back();
    t_busy_ignore();
    t_store_gate();
    t_corrupt();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule